// File: doc/BRIEF.md
# Multi-Address I2C Target Address Filter

This block sits behind an I2C byte receiver and decides, one byte at a time, whether the target should acknowledge. The receiver handles the SCL and SDA bit timing. It reports each completed byte with one of two strobes: one for the first byte after a START or repeated START, and one for every later byte. The first byte holds a 7-bit address and a direction bit. The filter compares that address against several address classes:

- a regular address taken from seven address pins;
- a shared all-call address;
- a set of programmable sub-addresses;
- a fixed software-reset address.

Every class except the regular one has its own enable.

On a match the block reports which class matched. Downstream logic uses this code to tell a broadcast write from a private one, or to start a reset sequence. For a write to a register-bearing class, the byte that follows is a register pointer. Its low five bits must fall inside the valid register range, or the transfer is refused. After any refusal the block keeps answering with no-acknowledge until the next address byte.

Top module: `addr_flt_top`

## Requirements
- R1: Bit 0 of the address byte is the direction: 1 means read and 0 means write. `rd_o` takes that bit at every address strobe. In a read transfer, later bytes get `ack_o`=0.
- R2: If address-byte bits [7:1] equal `addr_pins_i`, the byte is acknowledged with `match_o`=2 (regular). No enable input affects this.
- R3: If address-byte bits [7:1] equal `allcall_addr_i` and `allcall_en_i` is 1, the byte is acknowledged with `match_o`=3 (all-call). If `allcall_en_i` is 0, that address alone is not acknowledged.
- R4: Sub-address k sits at bits [7k+6:7k] of `sub_addr_i` and is enabled by `sub_en_i[k]`. A hit is acknowledged with `match_o`=4+k. A disabled sub-address is not acknowledged.
- R5: The software-reset address (parameter, default 7'h03, so byte 06h) is acknowledged with `match_o`=1 only when the direction bit is 0. A read to it gets no acknowledge unless another class matches.
- R6: When several classes hit, the reported class is chosen in this order: software reset, then regular, then all-call, then sub 0, sub 1, sub 2.
- R7: In a write to a class other than software reset, the byte after the address is a pointer. It is acknowledged when bits [4:0] are at most 1Bh; bits [7:5] are ignored. A pointer of 1Ch to 1Fh gets `ack_o`=0 and sets `match_o` to 0.
- R8: An address byte that matches nothing gives `ack_o`=0 and `match_o`=0. After a refusal, every byte up to the next address strobe gets `ack_o`=0.
- R9: The address and enable inputs are used only in the cycle of the address strobe. Changing them later in a transfer changes neither `match_o` nor the acknowledges of later bytes.
- R10: Outputs change only on the clock edge where a strobe is high, one cycle after the strobe, and hold otherwise. After reset, `ack_o`, `match_o` and `rd_o` are 0. Data bytes after an accepted pointer, and every byte after an accepted software-reset write, get `ack_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_stb_i | input | 1 | First byte after a START has completed |
| byte_stb_i | input | 1 | A later byte has completed |
| rx_byte_i | input | 8 | Received byte |
| addr_pins_i | input | 7 | Regular address from the pins |
| allcall_addr_i | input | 7 | All-call address |
| allcall_en_i | input | 1 | All-call enable |
| sub_addr_i | input | 7*NSUB | Sub-addresses, sub k at bits [7k+6:7k] |
| sub_en_i | input | NSUB | Per-sub-address enable |
| ack_o | output | 1 | Acknowledge decision for the last strobed byte |
| match_o | output | MATCH_W | Matched class: 0 none, 1 reset, 2 regular, 3 all-call, 4+k sub k |
| rd_o | output | 1 | Direction of the current transfer |

## Verification
The hardest situation to reach is an address byte that hits several enabled classes at once, since independent random values almost never collide. The stimulus therefore draws each address byte from a pool made of the configured addresses and the reset address. It also sometimes copies one configured address into another, or onto the pin value, so that the priority order is exercised. The bench changes the address and enable inputs in the middle of transfers to show that a decision already made stays fixed.

// File: rtl/addr_flt_pkg.sv
package addr_flt_pkg;

  localparam int CLS_NONE    = 0;
  localparam int CLS_RESET   = 1;
  localparam int CLS_REGULAR = 2;
  localparam int CLS_ALLCALL = 3;
  localparam int CLS_SUB0    = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2,
    PH_READ = 2'd3
  } phase_e;

  // Address compare: the upper seven bits of the byte carry the address.
  function automatic logic addr_eq(input logic [7:0] b, input logic [6:0] a);
    return b[7:1] == a;
  endfunction

  // Pointer range check: only the low five bits select a register.
  function automatic logic ptr_in_range(input logic [7:0] p, input logic [4:0] last);
    return p[4:0] <= last;
  endfunction

endpackage

// File: rtl/addr_flt_cmp.sv
module addr_flt_cmp
  import addr_flt_pkg::*;
#(
  parameter int          NSUB       = 3,
  parameter logic [6:0]  SWRST_ADDR = 7'h03,
  localparam int         NHIT       = NSUB + 3
) (
  input  logic [7:0]        rx_byte_i,
  input  logic [6:0]        addr_pins_i,
  input  logic [6:0]        allcall_addr_i,
  input  logic              allcall_en_i,
  input  logic [NSUB*7-1:0] sub_addr_i,
  input  logic [NSUB-1:0]   sub_en_i,
  output logic [NHIT-1:0]   hit_o
);

  // bit 0 reset call (write only), bit 1 regular, bit 2 all-call, bit 3+k sub k
  assign hit_o[0] = addr_eq(rx_byte_i, SWRST_ADDR) && !rx_byte_i[0];
  assign hit_o[1] = addr_eq(rx_byte_i, addr_pins_i);
  assign hit_o[2] = addr_eq(rx_byte_i, allcall_addr_i) && allcall_en_i;

  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    assign hit_o[3+k] = addr_eq(rx_byte_i, sub_addr_i[7*k +: 7]) && sub_en_i[k];
  end

endmodule

// File: rtl/addr_flt_prio.sv
module addr_flt_prio #(
  parameter int N  = 6,
  parameter int MW = 3
) (
  input  logic [N-1:0]  hit_i,
  output logic [N-1:0]  sel_o,
  output logic [MW-1:0] code_o
);

  // Lowest index wins; the reported code is the index plus one, zero for none.
  always_comb begin
    sel_o  = '0;
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel_o    = '0;
        sel_o[i] = 1'b1;
        code_o   = MW'(i + 1);
      end
    end
  end

endmodule

// File: rtl/addr_flt_top.sv
module addr_flt_top
  import addr_flt_pkg::*;
#(
  parameter int          NSUB       = 3,
  parameter logic [6:0]  SWRST_ADDR = 7'h03,
  parameter logic [4:0]  LAST_REG   = 5'h1B,
  localparam int         MATCH_W    = $clog2(NSUB + 4)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_stb_i,
  input  logic                byte_stb_i,
  input  logic [7:0]          rx_byte_i,
  input  logic [6:0]          addr_pins_i,
  input  logic [6:0]          allcall_addr_i,
  input  logic                allcall_en_i,
  input  logic [NSUB*7-1:0]   sub_addr_i,
  input  logic [NSUB-1:0]     sub_en_i,
  output logic                ack_o,
  output logic [MATCH_W-1:0]  match_o,
  output logic                rd_o
);

  localparam int NHIT = NSUB + 3;

  logic [NHIT-1:0]    hit;
  logic [NHIT-1:0]    sel;
  logic [MATCH_W-1:0] cls_code;
  phase_e             phase_q;

  // Named events for the checker
  logic ptr_phase;
  logic ptr_ok;
  logic addr_accept;

  addr_flt_cmp #(
    .NSUB       (NSUB),
    .SWRST_ADDR (SWRST_ADDR)
  ) i_cmp (
    .rx_byte_i      (rx_byte_i),
    .addr_pins_i    (addr_pins_i),
    .allcall_addr_i (allcall_addr_i),
    .allcall_en_i   (allcall_en_i),
    .sub_addr_i     (sub_addr_i),
    .sub_en_i       (sub_en_i),
    .hit_o          (hit)
  );

  addr_flt_prio #(
    .N  (NHIT),
    .MW (MATCH_W)
  ) i_prio (
    .hit_i  (hit),
    .sel_o  (sel),
    .code_o (cls_code)
  );

  assign ptr_phase   = (phase_q == PH_PTR);
  assign ptr_ok      = ptr_in_range(rx_byte_i, LAST_REG);
  assign addr_accept = addr_stb_i && (cls_code != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      match_o <= '0;
      rd_o    <= 1'b0;
      phase_q <= PH_IDLE;
    end else if (addr_stb_i) begin
      rd_o <= rx_byte_i[0];
      if (addr_accept) begin
        ack_o   <= 1'b1;
        match_o <= cls_code;
        if (rx_byte_i[0])
          phase_q <= PH_READ;
        else if (cls_code == MATCH_W'(CLS_RESET))
          phase_q <= PH_DATA;
        else
          phase_q <= PH_PTR;
      end else begin
        ack_o   <= 1'b0;
        match_o <= '0;
        phase_q <= PH_IDLE;
      end
    end else if (byte_stb_i) begin
      unique case (phase_q)
        PH_IDLE: ack_o <= 1'b0;
        PH_PTR: begin
          if (ptr_ok) begin
            ack_o   <= 1'b1;
            phase_q <= PH_DATA;
          end else begin
            ack_o   <= 1'b0;
            match_o <= '0;
            phase_q <= PH_IDLE;
          end
        end
        PH_DATA: ack_o <= 1'b1;
        PH_READ: ack_o <= 1'b0;
        default: ack_o <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/addr_flt_chk.sv
module addr_flt_chk #(
  parameter int         NHIT     = 6,
  parameter int         MW       = 3,
  parameter logic [4:0] LAST_REG = 5'h1B
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            addr_stb_i,
  input logic            byte_stb_i,
  input logic [7:0]      rx_byte_i,
  input logic            ack_o,
  input logic [MW-1:0]   match_o,
  input logic            rd_o,
  input logic            ptr_phase,
  input logic [NHIT-1:0] sel
);

  // R5: a reset-call match never belongs to a read
  a_r5_reset_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o == MW'(1)) |-> !rd_o);

  // R2: after an address byte, ack and a non-zero class go together
  a_r2_ack_with_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_stb_i |=> (ack_o == (match_o != '0)));

  // R8: with no class active, later bytes stay refused
  a_r8_hold_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !addr_stb_i && match_o == '0) |=> (!ack_o && match_o == '0));

  // R7: a reserved pointer is refused and drops the class
  a_r7_reserved_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !addr_stb_i && ptr_phase && rx_byte_i[4:0] > LAST_REG)
      |=> (!ack_o && match_o == '0));

  // R1: bytes of a read transfer are not acknowledged by the target
  a_r1_read_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !addr_stb_i && rd_o) |=> !ack_o);

  // R10: outputs hold when no strobe is present
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_stb_i && !byte_stb_i) |=> ($stable(ack_o) && $stable(match_o) && $stable(rd_o)));

  // R6: the priority stage selects at most one class
  a_r6_one_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

endmodule

bind addr_flt_top addr_flt_chk #(
  .NHIT     (NSUB + 3),
  .MW       (MATCH_W),
  .LAST_REG (LAST_REG)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_stb_i (addr_stb_i),
  .byte_stb_i (byte_stb_i),
  .rx_byte_i  (rx_byte_i),
  .ack_o      (ack_o),
  .match_o    (match_o),
  .rd_o       (rd_o),
  .ptr_phase  (ptr_phase),
  .sel        (sel)
);

// File: tb/test_addr_flt_top.sv
module test_addr_flt_top;

  localparam int NSUB = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              addr_stb = 1'b0;
  logic              byte_stb = 1'b0;
  logic [7:0]        rx = '0;
  logic [6:0]        pins = 7'h15;
  logic [6:0]        ac_addr = 7'h70;
  logic              ac_en = 1'b1;
  logic [NSUB*7-1:0] sub_addr = {7'h74, 7'h72, 7'h71};
  logic [NSUB-1:0]   sub_en = '0;
  logic              ack;
  logic [2:0]        match;
  logic              rd;

  int total = 0;
  int bad = 0;

  // bench model state
  int m_ph = 0;   // 0 idle, 1 pointer, 2 data, 3 read
  int m_cls = 0;
  bit m_ack = 0;
  bit m_rd = 0;

  always #10 clk = ~clk;

  addr_flt_top i_addr_flt_top (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .addr_stb_i     (addr_stb),
    .byte_stb_i     (byte_stb),
    .rx_byte_i      (rx),
    .addr_pins_i    (pins),
    .allcall_addr_i (ac_addr),
    .allcall_en_i   (ac_en),
    .sub_addr_i     (sub_addr),
    .sub_en_i       (sub_en),
    .ack_o          (ack),
    .match_o        (match),
    .rd_o           (rd)
  );

  function automatic int exp_cls(input logic [7:0] b);
    if (b[7:1] == 7'h03 && b[0] == 1'b0) return 1;
    if (b[7:1] == pins) return 2;
    if (ac_en && b[7:1] == ac_addr) return 3;
    for (int k = 0; k < NSUB; k++)
      if (sub_en[k] && b[7:1] == sub_addr[7*k +: 7]) return 4 + k;
    return 0;
  endfunction

  task automatic check(input string tag);
    total++;
    if (ack !== m_ack || match !== 3'(m_cls) || rd !== m_rd) begin
      bad++;
      $display("FAIL %s: ack/match/rd actual=%0b/%0d/%0b expected=%0b/%0d/%0b",
               tag, ack, match, rd, m_ack, m_cls, m_rd);
    end
  endtask

  task automatic send_addr(input logic [7:0] b, input string tag);
    int c;
    c = exp_cls(b);
    @(negedge clk);
    addr_stb = 1'b1; rx = b;
    @(negedge clk);
    addr_stb = 1'b0;
    m_rd = b[0];
    if (c == 0) begin m_ack = 0; m_cls = 0; m_ph = 0; end
    else begin
      m_ack = 1; m_cls = c;
      m_ph = b[0] ? 3 : (c == 1 ? 2 : 1);
    end
    check(tag);
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    @(negedge clk);
    byte_stb = 1'b1; rx = b;
    @(negedge clk);
    byte_stb = 1'b0;
    case (m_ph)
      1: if (b[4:0] <= 5'h1B) begin m_ack = 1; m_ph = 2; end
         else begin m_ack = 0; m_ph = 0; m_cls = 0; end
      2: m_ack = 1;
      default: m_ack = 0;
    endcase
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 regular address with all enables cleared
    ac_en = 0; sub_en = '0;
    send_addr({7'h15, 1'b0}, "R2 regular write");
    send_byte(8'h05, "R7 pointer 05h");
    send_byte(8'hA5, "R10 data ack");
    // R4 sub-address disabled, then enabled
    send_addr(8'hE4, "R4 disabled sub nack");
    send_byte(8'h00, "R8 held nack");
    sub_en = 3'b010;
    send_addr(8'hE4, "R4 sub1 ack");
    // R3 all-call enable
    send_addr(8'hE0, "R3 allcall disabled");
    ac_en = 1;
    send_addr(8'hE0, "R3 allcall enabled");
    // R5 reset call
    send_addr(8'h06, "R5 reset write");
    send_byte(8'hA5, "R10 reset data ack");
    send_addr(8'h07, "R5 reset read nack");
    // R1 read transfer
    send_addr({7'h15, 1'b1}, "R1 read addr");
    send_byte(8'h3C, "R1 read byte no ack");
    // R6 priority
    pins = 7'h70;
    send_addr(8'hE0, "R6 regular over allcall");
    pins = 7'h15; sub_addr[6:0] = 7'h70; sub_en = 3'b111;
    send_addr(8'hE0, "R6 allcall over sub");
    sub_addr[6:0] = 7'h72;
    send_addr(8'hE4, "R6 sub0 over sub1");
    sub_addr[6:0] = 7'h71;
    pins = 7'h03;
    send_addr(8'h06, "R6 reset over regular");
    send_addr(8'h07, "R6 read falls to regular");
    pins = 7'h15;
    // R7 boundaries
    send_addr(8'h2A, "R7 addr");
    send_byte(8'h1B, "R7 pointer 1Bh");
    send_addr(8'h2A, "R7 addr");
    send_byte(8'hFB, "R7 upper bits ignored");
    send_addr(8'h2A, "R7 addr");
    send_byte(8'h1C, "R7 pointer 1Ch refused");
    send_byte(8'h00, "R8 after refusal");
    send_addr(8'h2A, "R7 addr");
    send_byte(8'hFF, "R7 pointer 1Fh refused");
    // R9 mid-transfer changes
    send_addr(8'hE2, "R9 sub0 ack");
    sub_en = '0; ac_en = 0; sub_addr = '0;
    send_byte(8'h04, "R9 pointer after change");
    send_byte(8'h11, "R9 data after change");
    sub_addr = {7'h74, 7'h72, 7'h71};

    // random transfers
    for (int n = 0; n < 400; n++) begin
      logic [7:0] b;
      int sel;
      int nb;
      pins   = 7'($urandom_range(0, 127));
      ac_en  = 1'($urandom);
      sub_en = 3'($urandom);
      if ($urandom_range(0, 3) == 0) pins = ac_addr;
      if ($urandom_range(0, 3) == 0) sub_addr[13:7] = sub_addr[6:0];
      else sub_addr[13:7] = 7'h72;
      sel = $urandom_range(0, 6);
      case (sel)
        0: b[7:1] = pins;
        1: b[7:1] = ac_addr;
        2: b[7:1] = sub_addr[6:0];
        3: b[7:1] = sub_addr[13:7];
        4: b[7:1] = sub_addr[20:14];
        5: b[7:1] = 7'h03;
        default: b[7:1] = 7'($urandom_range(0, 127));
      endcase
      b[0] = 1'($urandom);
      send_addr(b, "R6 random address");
      nb = $urandom_range(0, 3);
      for (int j = 0; j < nb; j++) begin
        if ($urandom_range(0, 2) == 0) begin
          pins = 7'($urandom_range(0, 127)); ac_en = 1'($urandom); sub_en = 3'($urandom);
        end
        send_byte(8'($urandom_range(0, 255)), "R9 random byte");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule